// File: doc/BRIEF.md
# Interrupt Aggregation Controller

This block gathers a set of interrupt request lines into a single interrupt output for a processor. The sources are split into 16-bit banks (two banks by default, 32 sources). Software sets up each source on its own: level or edge detection, which level or edge counts as active, and whether the source may reach the output.

Every source line passes through a synchroniser. It then drives a pending bit. In level mode the pending bit follows the active level. In edge mode it latches the active edge and holds it until software writes a 1 to the matching bit of a clear-command register. The output is the OR of all enabled pending bits, driven with a polarity that software chooses.

Software uses a simple synchronous register port. Writes take effect on the rising clock edge. Reads are combinational from the address. The status view shows the pending bits before the enable mask is applied.

Top module: `irq_agg_top`

## Requirements
- R1: After reset, all configuration registers read 0. With all sources disabled and the output-polarity bit at 0, `irq_o` is 1 (deasserted).
- R2: A source whose mode bit is 0 (level) has its pending bit equal to the current active level of the synchronised input. Polarity bit 1 means high is active; polarity bit 0 means low is active.
- R3: A source whose mode bit is 1 (edge) sets its pending bit on an active edge. The bit stays set after the input returns, until it is cleared.
- R4: In edge mode, polarity bit 1 selects the rising edge and polarity bit 0 selects the falling edge.
- R5: Writing the clear-command register clears the edge-mode pending bit of every source whose data bit is 1. Sources whose data bit is 0 keep their pending bit. A level-mode pending bit is not affected by a clear.
- R6: If an active edge is detected in the same cycle as a clear of that source, the pending bit stays set.
- R7: The output is asserted when at least one source is both pending and enabled. A pending source whose enable bit is 0 does not assert the output.
- R8: With output-polarity bit 1, the asserted output is 1. With output-polarity bit 0, the asserted output is 0, and the deasserted output is the opposite value.
- R9: The status registers return the pending bits whether or not the sources are enabled.
- R10: A change on a source input shows in status on the third rising edge after it. It shows on `irq_o` on the fourth rising edge.
- R11: Register address is {field[2:0], bank[0]}. Fields: 0 mode, 1 enable, 2 clear command, 3 polarity, 4 status, 5 output polarity (bank 0 only, bit 0). Bank 0 holds sources 0-15 and bank 1 holds sources 16-31, with bit n standing for source n of the bank. Mode, enable, polarity and output polarity read back what was written. The clear command and all unused addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Interrupt source lines, asynchronous |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address {field, bank} |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data, combinational from the address |
| irq_o | output | 1 | Aggregated interrupt output, polarity set by software |

## Verification
Timing is counted from the rising edge after a source change. The pending bit is due on the third rising edge and the output on the fourth. Each check samples at the falling edge that follows that count. The latency test also samples one edge earlier, to confirm the result has not yet appeared. Register writes, clears and configuration changes take effect on the edge of the write, and the output follows one edge later. The coincident edge-and-clear case is timed so that the clear write lands exactly on the edge where the edge is detected.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  typedef enum logic [2:0] {
    F_MODE   = 3'd0,
    F_EN     = 3'd1,
    F_CLR    = 3'd2,
    F_POL    = 3'd3,
    F_STAT   = 3'd4,
    F_OUTPOL = 3'd5
  } field_e;
endpackage

// File: rtl/irq_agg_regs.sv
module irq_agg_regs
  import irq_agg_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = 16,
  parameter int ADDR_W    = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [BANK_W-1:0]             wdata_i,
  input  logic [NUM_BANKS*BANK_W-1:0]   stat_i,
  output logic [BANK_W-1:0]             rdata_o,
  output logic [NUM_BANKS*BANK_W-1:0]   mode_o,
  output logic [NUM_BANKS*BANK_W-1:0]   en_o,
  output logic [NUM_BANKS*BANK_W-1:0]   pol_o,
  output logic [NUM_BANKS*BANK_W-1:0]   clr_o,
  output logic                          outpol_o
);
  localparam int NUM_SRC = NUM_BANKS * BANK_W;
  localparam int BSEL_W  = $clog2(NUM_BANKS);

  logic [NUM_SRC-1:0] mode_q, mode_d, en_q, en_d, pol_q, pol_d;
  logic               outpol_q, outpol_d;
  field_e             fld;
  logic [BSEL_W-1:0]  bank;

  assign fld  = field_e'(addr_i[ADDR_W-1:BSEL_W]);
  assign bank = addr_i[BSEL_W-1:0];

  always_comb begin
    mode_d   = mode_q;
    en_d     = en_q;
    pol_d    = pol_q;
    outpol_d = outpol_q;
    clr_o    = '0;
    rdata_o  = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank == BSEL_W'(b)) begin
        if (wr_i) begin
          case (fld)
            F_MODE:  mode_d[b*BANK_W +: BANK_W] = wdata_i;
            F_EN:    en_d[b*BANK_W +: BANK_W]   = wdata_i;
            F_POL:   pol_d[b*BANK_W +: BANK_W]  = wdata_i;
            F_CLR:   clr_o[b*BANK_W +: BANK_W]  = wdata_i;
            default: ;
          endcase
        end
        case (fld)
          F_MODE:  rdata_o = mode_q[b*BANK_W +: BANK_W];
          F_EN:    rdata_o = en_q[b*BANK_W +: BANK_W];
          F_POL:   rdata_o = pol_q[b*BANK_W +: BANK_W];
          F_STAT:  rdata_o = stat_i[b*BANK_W +: BANK_W];
          default: ;
        endcase
      end
    end
    if (fld == F_OUTPOL && bank == '0) begin
      if (wr_i) outpol_d = wdata_i[0];
      rdata_o = {{(BANK_W-1){1'b0}}, outpol_q};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      en_q     <= '0;
      pol_q    <= '0;
      outpol_q <= 1'b0;
    end else if (wr_i) begin
      mode_q   <= mode_d;
      en_q     <= en_d;
      pol_q    <= pol_d;
      outpol_q <= outpol_d;
    end
  end

  assign mode_o   = mode_q;
  assign en_o     = en_q;
  assign pol_o    = pol_q;
  assign outpol_o = outpol_q;
endmodule

// File: rtl/irq_agg_bank.sv
module irq_agg_bank #(
  parameter int BANK_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] src_i,
  input  logic [BANK_W-1:0] mode_i,
  input  logic [BANK_W-1:0] pol_i,
  input  logic [BANK_W-1:0] clr_i,
  output logic [BANK_W-1:0] pend_o
);
  logic [SYNC_STAGES-1:0][BANK_W-1:0] sync_q, sync_d;
  logic [BANK_W-1:0] act, act_q, edge_w, pend_q, pend_d;

  always_comb begin
    sync_d[0] = src_i;
    for (int s = 1; s < SYNC_STAGES; s++) sync_d[s] = sync_q[s-1];
  end

  // active level: high when polarity bit set, low otherwise
  assign act    = sync_q[SYNC_STAGES-1] ~^ pol_i;
  assign edge_w = act & ~act_q;
  assign pend_d = (mode_i & (edge_w | (pend_q & ~clr_i))) | (~mode_i & act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      act_q  <= '0;
      pend_q <= '0;
    end else begin
      sync_q <= sync_d;
      act_q  <= act;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

  for (genvar i = 0; i < BANK_W; i++) begin : g_chk
    assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i[i] && pend_q[i] && !clr_i[i]) |=> pend_q[i]);
    assert_edge_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i[i] && edge_w[i] && clr_i[i]) |=> pend_q[i]);
    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i[i] && clr_i[i] && !edge_w[i]) |=> !pend_q[i]);
  end
endmodule

// File: rtl/irq_agg_out.sv
module irq_agg_out #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic               outpol_i,
  output logic               irq_o
);
  logic any_w, irq_d, irq_q;

  assign any_w = |(pend_i & en_i);
  assign irq_d = any_w ~^ outpol_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b1;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  assert_idle_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (~|(pend_i & en_i)) |=> (irq_o == !$past(outpol_i)));
endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top #(
  parameter int NUM_BANKS   = 2,
  parameter int BANK_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_BANKS*BANK_W-1:0] src_i,
  input  logic                        reg_wr_i,
  input  logic [ADDR_W-1:0]           reg_addr_i,
  input  logic [BANK_W-1:0]           reg_wdata_i,
  output logic [BANK_W-1:0]           reg_rdata_o,
  output logic                        irq_o
);
  localparam int NUM_SRC = NUM_BANKS * BANK_W;

  logic [1:0]         rst_pipe;
  logic               rst_sync_n;
  logic [NUM_SRC-1:0] mode, en, pol, clr, pend;
  logic               outpol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  irq_agg_regs #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .stat_i(pend), .rdata_o(reg_rdata_o),
    .mode_o(mode), .en_o(en), .pol_o(pol), .clr_o(clr), .outpol_o(outpol)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    irq_agg_bank #(.BANK_W(BANK_W), .SYNC_STAGES(SYNC_STAGES)) u_bank (
      .clk(clk), .rst_n(rst_sync_n),
      .src_i (src_i[b*BANK_W +: BANK_W]),
      .mode_i(mode[b*BANK_W +: BANK_W]),
      .pol_i (pol[b*BANK_W +: BANK_W]),
      .clr_i (clr[b*BANK_W +: BANK_W]),
      .pend_o(pend[b*BANK_W +: BANK_W])
    );
  end

  irq_agg_out #(.NUM_SRC(NUM_SRC)) u_out (
    .clk(clk), .rst_n(rst_sync_n), .pend_i(pend), .en_i(en),
    .outpol_i(outpol), .irq_o(irq_o)
  );
endmodule

// File: tb/tb_irq_agg_top.sv
`timescale 1ns/1ps
module tb_irq_agg_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        wr = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_agg_top dut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  typedef struct packed {
    logic [31:0] mode, pol, en, src_a, src_b;
    logic        outpol;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{32'h0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0, 32'h00000100, 1'b1},
    '{32'h0, 32'h0, 32'hFFFF0000, 32'h0, 32'hFFFFFFFE, 1'b0},
    '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0, 32'hA5A50003, 1'b1},
    '{32'hFFFFFFFF, 32'h0, 32'h80000000, 32'hFFFFFFFF, 32'h7FFFFFFF, 1'b0},
    '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFF0000, 32'hFFFF0000, 1'b1},
    '{32'h0000FFFF, 32'h00FF00FF, 32'hFFFFFFFF, 32'h12345678, 32'h87654321, 1'b1}
  };

  function automatic logic [31:0] model_pend(vec_t v);
    logic [31:0] a0, a1;
    a0 = ~(v.src_a ^ v.pol);
    a1 = ~(v.src_b ^ v.pol);
    return (v.mode & a1 & ~a0) | (~v.mode & a1);
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic wreg(logic [3:0] a, logic [15:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rreg(logic [3:0] a, output logic [15:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic config_all(logic [31:0] m, logic [31:0] p, logic [31:0] e, logic op);
    wreg(4'd0, m[15:0]);  wreg(4'd1, m[31:16]);
    wreg(4'd6, p[15:0]);  wreg(4'd7, p[31:16]);
    wreg(4'd2, e[15:0]);  wreg(4'd3, e[31:16]);
    wreg(4'd10, {15'd0, op});
  endtask

  task automatic clear_all();
    wreg(4'd4, 16'hFFFF);
    wreg(4'd5, 16'hFFFF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lo, hi;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);

    // R1 reset state
    rreg(4'd0, lo); chk("R1 mode lo", {16'd0, lo}, 0);
    rreg(4'd3, lo); chk("R1 en hi", {16'd0, lo}, 0);
    rreg(4'd10, lo); chk("R1 outpol", {16'd0, lo}, 0);
    chk("R1 irq idle", {31'd0, irq}, 1);

    // R11 register map
    wreg(4'd2, 16'h5A5A);
    rreg(4'd2, lo); chk("R11 en readback", {16'd0, lo}, 32'h5A5A);
    rreg(4'd4, lo); chk("R11 clear reads zero", {16'd0, lo}, 0);
    rreg(4'd15, lo); chk("R11 unused reads zero", {16'd0, lo}, 0);
    wreg(4'd7, 16'hC3C3);
    rreg(4'd7, lo); chk("R11 pol hi readback", {16'd0, lo}, 32'hC3C3);

    // Table: R2 R4 R7 R8 R9
    foreach (VEC[k]) begin
      vec_t v;
      logic [31:0] ep;
      v = VEC[k];
      @(negedge clk) src = v.src_a;
      config_all(v.mode, v.pol, v.en, v.outpol);
      repeat (5) @(posedge clk);
      clear_all();
      @(negedge clk) src = v.src_b;
      repeat (3) @(posedge clk);
      ep = model_pend(v);
      @(negedge clk);
      rreg(4'd8, lo);
      @(negedge clk);
      rreg(4'd9, hi);
      chk($sformatf("R2 R4 R9 status vec%0d", k), {hi, lo}, ep);
      chk($sformatf("R7 R8 irq vec%0d", k), {31'd0, irq},
          {31'd0, ~((|(ep & v.en)) ^ v.outpol)});
    end

    // R10 latency, edge mode rising, enabled, active-high output
    @(negedge clk) src = '0;
    config_all(32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000001, 1'b1);
    repeat (5) @(posedge clk);
    clear_all();
    @(negedge clk) src = 32'h1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rreg(4'd8, lo); chk("R10 status not yet", {16'd0, lo}, 0);
    @(negedge clk);
    rreg(4'd8, lo); chk("R10 status on third edge", {16'd0, lo}, 1);
    chk("R10 irq not yet", {31'd0, irq}, 0);
    @(negedge clk);
    chk("R10 irq on fourth edge", {31'd0, irq}, 1);

    // R3 sticky after input returns
    @(negedge clk) src = 32'h80;
    repeat (2) @(posedge clk);
    @(negedge clk) src = 32'h0;
    repeat (6) @(posedge clk);
    @(negedge clk);
    rreg(4'd8, lo); chk("R3 sticky pending", {16'd0, lo}, 32'h81);

    // R6 / R5 edge vs clear, selective clear
    clear_all();
    @(negedge clk) src = 32'h20;
    repeat (6) @(posedge clk);
    @(negedge clk) src = 32'h24;
    repeat (2) @(posedge clk);
    wreg(4'd4, 16'h0004);
    rreg(4'd8, lo); chk("R6 edge beats clear", {16'd0, lo}, 32'h24);
    wreg(4'd4, 16'h0004);
    rreg(4'd8, lo); chk("R5 selective clear", {16'd0, lo}, 32'h20);
    wreg(4'd4, 16'h0020);
    rreg(4'd8, lo); chk("R5 clear remaining", {16'd0, lo}, 0);

    // R5 clear does not touch level-mode pending
    config_all(32'h0, 32'hFFFFFFFF, 32'h0, 1'b0);
    @(negedge clk) src = 32'h00010001;
    repeat (5) @(posedge clk);
    clear_all();
    @(negedge clk);
    rreg(4'd8, lo); rreg(4'd9, hi);
    chk("R5 level ignores clear", {hi, lo}, 32'h00010001);
    chk("R7 disabled no irq", {31'd0, irq}, 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule